// File: doc/BRIEF.md
# Systolic FIR Filter Array

This block is a linear chain of identical multiply-accumulate elements that together form a finite impulse response filter. Each element holds one coefficient. It forwards the incoming sample to its neighbour through a single register and forwards its running partial sum through a pair of registers. The mismatch between the two path delays lines up every sample with the correct coefficient as both streams travel down the chain. The partial sum leaving the last element is the filter result.

There is one input port, and it is time-shared. Coefficients arrive on it first and travel down the sample path, and every element captures its own coefficient on the same clock edge. After that, the port carries samples. Once loading is done, the elements alternate between an accumulate phase and an output-shift phase. A sample is taken in each accumulate phase, and the value present during the shift phase is ignored. An output-valid flag tells the consumer when the first result built entirely from real samples is on the output.

Top module: `fir_systolic`

## Requirements
- R1: While `rst_ni` is low, `y_o` is 0 and `valid_o` is 0. After release, the first rising edge moves every element from idle into weight load.
- R2: The NTAPS values on `din_i` during the NTAPS cycles that follow the idle cycle are the coefficients, in the order w(0), w(1), … w(NTAPS-1), one per clock. All elements capture their coefficient at the end of the last load cycle, and `y_o` stays 0 during loading.
- R3: After loading, the elements alternate strictly between accumulate and output shift, and all of them stay in lockstep. A sample is taken on `din_i` in the first cycle after loading and in every second cycle after that. The value on `din_i` during the shift cycles has no effect on the output.
- R4: The output computes y(t) = Σ_{k=0}^{NTAPS-1} w(k)·x(t-k), where x(t) is the t-th sample taken after loading. All values are two's-complement signed.
- R5: y(t) appears on `y_o` at the edge that takes sample t+NTAPS. It holds for two clock cycles, and `y_o` changes only at the end of an accumulate cycle.
- R6: `valid_o` rises at the edge that takes sample 2·NTAPS-1, which is when y(NTAPS-1) first appears. It stays high until reset and is low throughout idle and load.
- R7: An asynchronous reset asserted in the middle of a stream clears `y_o` and `valid_o` at once. The block then restarts from idle, with a fresh coefficient load.
- R8: Products keep full precision, and the output is 2·DW+clog2(NTAPS) bits wide. Full-scale negative coefficients times full-scale negative or positive samples give exact sums with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | DW | Shared coefficient/sample input, signed |
| y_o | output | 2·DW+clog2(NTAPS) | Filter output, signed |
| valid_o | output | 1 | Output holds a result from a full window of samples |

## Verification
Two functions share one edge: coefficient capture and sample forwarding. On the final load edge, every element latches its coefficient from the same sample-path registers that are shifting at that moment. The very next cycle is already an accumulate cycle. This is provoked by loading distinct coefficients and then feeding an impulse, so that each expected output names exactly one element's captured value, and by a second load with full-scale values after a mid-stream reset. Shift-cycle junk on the input is driven throughout, and a scoreboard compares each valid output against sums computed from the applied samples.

// File: rtl/fir_sys_pkg.sv
`timescale 1ns/1ps
package fir_sys_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_MAC   = 2'd2,
    ST_SHIFT = 2'd3
  } pe_state_e;

endpackage

// File: rtl/fir_pe_ctl.sv
`timescale 1ns/1ps
module fir_pe_ctl
  import fir_sys_pkg::*;
#(
  parameter int NTAPS = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  output pe_state_e state_o,
  output logic      wcap_o
);

  localparam int CW = (NTAPS > 1) ? $clog2(NTAPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(NTAPS - 1);

  pe_state_e     st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_q  <= ST_LOAD;
          cnt_q <= '0;
        end
        ST_LOAD: begin
          if (cnt_q == LAST) st_q <= ST_MAC;
          else               cnt_q <= cnt_q + 1'b1;
        end
        ST_MAC:   st_q <= ST_SHIFT;
        ST_SHIFT: st_q <= ST_MAC;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st_q;
  // all elements count in lockstep, so all capture on the same edge
  assign wcap_o  = (st_q == ST_LOAD) && (cnt_q == LAST);

endmodule

// File: rtl/fir_pe.sv
`timescale 1ns/1ps
module fir_pe
  import fir_sys_pkg::*;
#(
  parameter int NTAPS = 4,
  parameter int DW    = 8,
  parameter int AW    = 18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [AW-1:0] y_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [AW-1:0] y_o,
  output pe_state_e            st_o
);

  pe_state_e st;
  logic      wcap;

  fir_pe_ctl #(.NTAPS(NTAPS)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (st),
    .wcap_o  (wcap)
  );

  logic signed [DW-1:0]   w_q, x_q;
  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   p1_q, p2_q;

  assign prod = (2*DW)'(w_q) * (2*DW)'(x_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q  <= '0;
      x_q  <= '0;
      p1_q <= '0;
      p2_q <= '0;
    end else begin
      if (wcap) w_q <= x_i;
      // sample register doubles as the weight forwarding path
      if (st == ST_LOAD || st == ST_MAC) x_q <= x_i;
      if (st == ST_MAC) begin
        p1_q <= y_i + AW'(prod);
        p2_q <= p1_q;
      end
    end
  end

  assign x_o  = x_q;
  assign y_o  = p2_q;
  assign st_o = st;

endmodule

// File: rtl/fir_out_valid.sv
`timescale 1ns/1ps
module fir_out_valid #(
  parameter int NTAPS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mac_i,
  output logic valid_o
);

  localparam int CNTW = $clog2(2 * NTAPS);
  localparam logic [CNTW-1:0] FILL = CNTW'(2 * NTAPS - 1);

  logic [CNTW-1:0] cnt_q;
  logic            vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else if (mac_i && !vld_q) begin
      if (cnt_q == FILL) vld_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = vld_q;

endmodule

// File: rtl/fir_systolic.sv
`timescale 1ns/1ps
module fir_systolic
  import fir_sys_pkg::*;
#(
  parameter  int NTAPS = 4,
  parameter  int DW    = 8,
  localparam int AW    = 2 * DW + $clog2(NTAPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] din_i,
  output logic signed [AW-1:0] y_o,
  output logic                 valid_o
);

  logic signed [DW-1:0] x_c [NTAPS];
  logic signed [AW-1:0] y_c [NTAPS];
  pe_state_e            st_w [NTAPS];
  logic signed [DW-1:0] x_unused;
  logic signed [AW-1:0] y_last;
  logic                 mac_all;

  assign x_c[0] = din_i;
  assign y_c[0] = '0;

  for (genvar k = 0; k < NTAPS; k++) begin : g_pe
    if (k < NTAPS - 1) begin : g_mid
      fir_pe #(.NTAPS(NTAPS), .DW(DW), .AW(AW)) u_pe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .x_i    (x_c[k]),
        .y_i    (y_c[k]),
        .x_o    (x_c[k+1]),
        .y_o    (y_c[k+1]),
        .st_o   (st_w[k])
      );
    end else begin : g_last
      fir_pe #(.NTAPS(NTAPS), .DW(DW), .AW(AW)) u_pe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .x_i    (x_c[k]),
        .y_i    (y_c[k]),
        .x_o    (x_unused),
        .y_o    (y_last),
        .st_o   (st_w[k])
      );
    end
  end

  always_comb begin
    mac_all = 1'b1;
    for (int k = 0; k < NTAPS; k++) begin
      if (st_w[k] != ST_MAC) mac_all = 1'b0;
    end
  end

  fir_out_valid #(.NTAPS(NTAPS)) u_vld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mac_i   (mac_all),
    .valid_o (valid_o)
  );

  assign y_o = y_last;

endmodule

// File: rtl/fir_systolic_chk.sv
`timescale 1ns/1ps
module fir_systolic_chk
  import fir_sys_pkg::*;
#(
  parameter int NTAPS = 4,
  parameter int AW    = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_o,
  input logic [AW-1:0] y_o,
  input pe_state_e     st_w [NTAPS]
);

  logic all_same;
  int   ld_cnt;

  always_comb begin
    all_same = 1'b1;
    for (int k = 1; k < NTAPS; k++) begin
      if (st_w[k] != st_w[0]) all_same = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ld_cnt <= 0;
    else if (st_w[0] == ST_LOAD) ld_cnt <= ld_cnt + 1;
    else                        ld_cnt <= 0;
  end

  p_idle_to_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w[0] == ST_IDLE) |=> (st_w[0] == ST_LOAD));

  p_load_stays_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w[0] == ST_LOAD && ld_cnt != NTAPS - 1) |=> (st_w[0] == ST_LOAD));

  p_load_ends_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w[0] == ST_LOAD && ld_cnt == NTAPS - 1) |=> (st_w[0] == ST_MAC));

  p_lockstep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_same);

  p_mac_then_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w[0] == ST_MAC) |=> (st_w[0] == ST_SHIFT));

  p_shift_then_mac_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w[0] == ST_SHIFT) |=> (st_w[0] == ST_MAC));

  p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w[0] != ST_MAC) |=> $stable(y_o));

  p_valid_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  p_no_valid_early_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_w[0] == ST_IDLE || st_w[0] == ST_LOAD) |-> !valid_o);

endmodule

bind fir_systolic fir_systolic_chk #(.NTAPS(NTAPS), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_o (valid_o),
  .y_o     (y_o),
  .st_w    (st_w)
);

// File: tb/fir_systolic_tb.sv
`timescale 1ns/1ps
module fir_systolic_tb;

  localparam int  NTAPS = 4;
  localparam int  DW    = 8;
  localparam int  AW    = 2 * DW + $clog2(NTAPS);
  localparam time TCLK  = 20ns;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic signed [AW-1:0] y;
  logic                 vld;

  always #(TCLK / 2) clk = ~clk;

  fir_systolic #(.NTAPS(NTAPS), .DW(DW)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .din_i   (din),
    .y_o     (y),
    .valid_o (vld)
  );

  typedef struct {
    int    val;
    string tag;
  } exp_t;

  exp_t        exp_q[$];
  int          hist[$];
  int          w_b[NTAPS];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cur_n = -1;
  bit          in_shift = 1'b0;
  bit          in_mac = 1'b0;
  bit          last_ok = 1'b0;
  int          last_y = 0;
  logic [31:0] seed = 32'h1234_5678;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // monitor: pops the scoreboard in every shift cycle
  always @(negedge clk) begin
    exp_t e;
    if (in_mac && last_ok)
      check(int'(y) == last_y, "R5 output held over accumulate cycle", int'(y), last_y);
    if (in_shift) begin
      check(vld == (cur_n >= 2 * NTAPS - 1), "R6 valid timing", int'(vld),
            int'(cur_n >= 2 * NTAPS - 1));
      if (vld) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 output without expected item", int'(y), 0);
        end else begin
          e = exp_q.pop_front();
          check(int'(y) == e.val, {e.tag, " R4 R5 filter output"}, int'(y), e.val);
        end
      end
      last_y  = int'(y);
      last_ok = 1'b1;
    end
  end

  task automatic apply_reset(input bit async_chk);
    in_mac   = 1'b0;
    in_shift = 1'b0;
    last_ok  = 1'b0;
    rst_n    = 1'b0;
    if (async_chk) begin
      #3;
      check(y == '0, "R7 async clear of output", int'(y), 0);
      check(vld == 1'b0, "R7 async clear of valid", int'(vld), 0);
    end
    exp_q.delete();
    hist.delete();
    cur_n = -1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(y == '0, "R1 reset output", int'(y), 0);
    check(vld == 1'b0, "R1 reset valid", int'(vld), 0);
    rst_n = 1'b1;
  endtask

  task automatic load_weights();
    @(posedge clk);
    #1;
    for (int j = 0; j < NTAPS; j++) begin
      din = DW'(w_b[j]);
      @(posedge clk);
      #1;
    end
    check(y == '0, "R2 output quiet after load", int'(y), 0);
    check(vld == 1'b0, "R6 valid low after load", int'(vld), 0);
  endtask

  // driver: one sample per accumulate cycle, junk in the shift cycle
  task automatic step(input int x, input string tag);
    int acc;
    din = DW'(x);
    hist.push_back(x);
    if (hist.size() >= NTAPS) begin
      acc = 0;
      for (int m = 0; m < NTAPS; m++) acc += w_b[m] * hist[hist.size() - 1 - m];
      exp_q.push_back('{acc, tag});
    end
    cur_n++;
    in_mac = 1'b1;
    @(posedge clk);
    #1;
    in_mac   = 1'b0;
    in_shift = 1'b1;
    seed     = seed * 32'd1103515245 + 32'd12345;
    din      = DW'(seed[23:16]);
    @(posedge clk);
    #1;
    in_shift = 1'b0;
  endtask

  initial begin
    #(TCLK * 50000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog R1-chain: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    apply_reset(1'b0);

    // R2: distinct weights, impulse response names each element's weight
    w_b = '{3, -5, 7, 2};
    load_weights();
    for (int i = 0; i < NTAPS - 1; i++) step(0, "R2");
    step(1, "R2");
    for (int i = 0; i < NTAPS; i++) step(0, "R2");

    // R4: ramp
    for (int i = 1; i <= 10; i++) step(i, "R4");

    // R3: pseudo-random samples, junk on every shift cycle
    for (int i = 0; i < 30; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      step(int'($signed(seed[15:8])), "R3");
    end

    // R7: reset in mid-stream, reload with full-scale weights
    apply_reset(1'b1);
    w_b = '{-128, -128, -128, -128};
    load_weights();
    for (int i = 0; i < 8; i++) step(-128, "R8");
    for (int i = 0; i < 6; i++) step(127, "R8");
    for (int i = 0; i < 10; i++) step((i % 2 == 0) ? -128 : 127, "R8");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule